// File: doc/BRIEF.md
# Periodic Timer and Watchdog

This peripheral pairs a free-running interval timer with a system watchdog behind one small register window. The timer counts input ticks against a 16-bit period. At the end of each period it reloads itself and raises a level-7 interrupt request. That request stays pending until software pulses a clear strobe. Once software has written a period, the timer runs for good. Reading the timer register returns the count as it stands at that moment, not the period that was written.

The watchdog counts ticks down from a programmed 16-bit timeout, and the timeout is linear in the programmed value. Setting the enable bit in the control byte starts the countdown. When the countdown runs out, the watchdog drives a system reset request for a fixed number of clock cycles and then returns to the disabled state. Software keeps the watchdog alive by rewriting the timeout and then writing the enable bit again. Clearing the enable bit stops the watchdog at any time.

Top module: `ptwd_top`

## Requirements
- R1: After reset, all three registers (timer at address 0, watchdog timeout at address 1, watchdog control at address 2) read 0, and irq7_o and wd_rst_o are low.
- R2: After a period N from 1 to 65535 is written to address 0, irq7_o goes high on the clock edge of the Nth tick. The timer then reloads N and repeats. A read of address 0 returns the live count: N minus (ticks mod N), or N when that remainder is 0.
- R3: A period of 0 gives a period of 65536 ticks. After 65535 ticks irq7_o is still low and the count reads 1. The next tick raises irq7_o and the count reads 0.
- R4: Once the timer has been written, it keeps counting whatever happens in the watchdog registers. A new write to address 0 restarts the count from the new period and does not stop the timer.
- R5: irq7_o stays high until a cycle in which irq_clr_i is high, and drops on the edge that ends that cycle. When a period end falls in the same cycle as the clear, irq7_o stays high.
- R6: The watchdog enable is bit 6 of the control byte at address 2. All 8 bits of the control byte read back in bits 7..0, and bits 15..8 read 0.
- R7: The watchdog expires on the clock edge of the Nth tick after it was enabled with timeout N (0 means 65536). wd_rst_o is then high for exactly RST_PULSE cycles, and control bit 6 reads 0 from then on.
- R8: Rewriting the timeout and then writing the control byte with bit 6 set restarts the countdown from the new timeout. Such a write wins over an expiry that falls in the same cycle.
- R9: Writing the control byte with bit 6 clear stops the watchdog, and wd_rst_o then stays low however many ticks follow.
- R10: Address 1 reads back the programmed timeout, not the remaining watchdog count. Counters move only on clock edges where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable for both counters, one tick per clock |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 timer, 1 watchdog timeout, 2 watchdog control |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for addr_i, combinational |
| irq_clr_i | input | 1 | Pulse to clear the pending timer interrupt |
| irq7_o | output | 1 | Level-7 timer interrupt request |
| wd_rst_o | output | 1 | Watchdog system reset request pulse |

## Verification
Two pairs of functions can fall in the same cycle. In the timer, a period end can meet the interrupt clear strobe. The bench runs the count down to 1 and then drives tick_i and irq_clr_i together, so the new request and the clear land on one edge. The request must still be pending afterwards, and a later clear on its own must remove it. In the watchdog, a kick can meet expiry. The bench kicks one tick before expiry and checks that no reset pulse appears for the full new timeout, and that one appears on exactly the last tick.

// File: rtl/ptwd_pkg.sv
package ptwd_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CTL_W  = 8;
  localparam int unsigned EN_BIT = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_TMR   = 2'd0,
    REG_WDPS  = 2'd1,
    REG_WDCTL = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ptwd_timer.sv
module ptwd_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             started_q, started_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             irq_q, irq_d;
  logic             wrap;

  assign wrap = started_q && tick_i && !load_i && (count_q == ONE);

  always_comb begin
    started_d = started_q;
    period_d  = period_q;
    count_d   = count_q;
    if (load_i) begin
      started_d = 1'b1;
      period_d  = load_val_i;
      count_d   = load_val_i;
    end else if (started_q && tick_i) begin
      if (count_q == ONE) count_d = period_q;
      else                count_d = count_q - ONE;
    end
    irq_d = wrap | (irq_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      period_q  <= '0;
      count_q   <= '0;
      irq_q     <= 1'b0;
    end else begin
      started_q <= started_d;
      period_q  <= period_d;
      count_q   <= count_d;
      irq_q     <= irq_d;
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/ptwd_wdog.sv
module ptwd_wdog
  import ptwd_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RST_PULSE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ps_wr_i,
  input  logic             ctl_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] ps_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             rst_req_o
);
  localparam int unsigned     PULSE_W = $clog2(RST_PULSE + 1);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0]   ps_q, ps_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CTL_W-1:0]   ctl_q, ctl_d;
  logic [PULSE_W-1:0] pulse_q, pulse_d;
  logic               expire;

  assign expire = ctl_q[EN_BIT] && tick_i && !ctl_wr_i && (cnt_q == ONE);

  always_comb begin
    ps_d    = ps_q;
    cnt_d   = cnt_q;
    ctl_d   = ctl_q;
    pulse_d = pulse_q;
    if (ps_wr_i) ps_d = wr_data_i;
    if (ctl_wr_i) begin
      ctl_d = wr_data_i[CTL_W-1:0];
      if (wr_data_i[EN_BIT]) cnt_d = ps_q;
    end else if (ctl_q[EN_BIT] && tick_i) begin
      if (cnt_q == ONE) ctl_d[EN_BIT] = 1'b0;
      else              cnt_d = cnt_q - ONE;
    end
    if (expire)              pulse_d = PULSE_W'(RST_PULSE);
    else if (pulse_q != '0)  pulse_d = pulse_q - PULSE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q    <= '0;
      cnt_q   <= '0;
      ctl_q   <= '0;
      pulse_q <= '0;
    end else begin
      ps_q    <= ps_d;
      cnt_q   <= cnt_d;
      ctl_q   <= ctl_d;
      pulse_q <= pulse_d;
    end
  end

  assign ps_o      = ps_q;
  assign ctl_o     = ctl_q;
  assign rst_req_o = (pulse_q != '0);
endmodule

// File: rtl/ptwd_top.sv
module ptwd_top
  import ptwd_pkg::*;
#(
  parameter int unsigned RST_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              irq_clr_i,
  output logic              irq7_o,
  output logic              wd_rst_o
);
  logic [DATA_W-1:0] tmr_count;
  logic [DATA_W-1:0] wd_ps;
  logic [CTL_W-1:0]  wd_ctl;
  logic              tmr_wr, ps_wr, ctl_wr;

  assign tmr_wr = wr_en_i && (addr_i == REG_TMR);
  assign ps_wr  = wr_en_i && (addr_i == REG_WDPS);
  assign ctl_wr = wr_en_i && (addr_i == REG_WDCTL);

  ptwd_timer #(.CNT_W(DATA_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .load_i     (tmr_wr),
    .load_val_i (wr_data_i),
    .clr_i      (irq_clr_i),
    .count_o    (tmr_count),
    .irq_o      (irq7_o)
  );

  ptwd_wdog #(.CNT_W(DATA_W), .RST_PULSE(RST_PULSE)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .ps_wr_i   (ps_wr),
    .ctl_wr_i  (ctl_wr),
    .wr_data_i (wr_data_i),
    .ps_o      (wd_ps),
    .ctl_o     (wd_ctl),
    .rst_req_o (wd_rst_o)
  );

  always_comb begin
    unique case (addr_i)
      REG_TMR:   rd_data_o = tmr_count;
      REG_WDPS:  rd_data_o = wd_ps;
      REG_WDCTL: rd_data_o = {{(DATA_W-CTL_W){1'b0}}, wd_ctl};
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/ptwd_chk.sv
module ptwd_chk #(
  parameter int unsigned RST_PULSE = 4
) (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic irq_clr_i,
  input logic irq7_o,
  input logic wd_rst_o
);
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (wd_rst_o) run_q <= run_q + 8'd1;
    else               run_q <= '0;
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq7_o && !irq_clr_i) |=> irq7_o); // R5

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq7_o && irq_clr_i && !tick_i) |=> !irq7_o); // R5

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq7_o && !tick_i) |=> !irq7_o); // R10

  AST_RST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_rst_o && !tick_i) |=> !wd_rst_o); // R7

  AST_RST_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_o |-> (run_q < 8'(RST_PULSE))); // R7

  AST_RST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst_o && (run_q < 8'(RST_PULSE - 1))) |=> wd_rst_o); // R7
endmodule

bind ptwd_top ptwd_chk #(.RST_PULSE(RST_PULSE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .irq_clr_i (irq_clr_i),
  .irq7_o    (irq7_o),
  .wd_rst_o  (wd_rst_o)
);

// File: tb/ptwd_top_tb_top.sv
module ptwd_top_tb_top;
  localparam int RST_PULSE = 4;
  localparam int NVEC = 6;
  localparam logic [15:0] V_PER [NVEC] = '{16'd5, 16'd5, 16'd5, 16'd1, 16'd200, 16'd0};
  localparam int          V_TCK [NVEC] = '{3, 5, 7, 4, 199, 3};

  logic        clk, rst_n, tick_i, wr_en_i, irq_clr_i;
  logic [1:0]  addr_i;
  logic [15:0] wr_data_i, rd_data_o;
  logic        irq7_o, wd_rst_o;
  int checks = 0;
  int errors = 0;

  ptwd_top #(.RST_PULSE(RST_PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .irq_clr_i(irq_clr_i), .irq7_o(irq7_o), .wd_rst_o(wd_rst_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic clr_irq();
    @(negedge clk);
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: bench timed out, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; irq_clr_i = 1'b0;
    addr_i = 2'd0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 timer", v, 0);
    rd(2'd1, v); chk("R1 wdps", v, 0);
    rd(2'd2, v); chk("R1 wdctl", v, 0);
    chk("R1 irq", irq7_o, 0);
    chk("R1 rst", wd_rst_o, 0);
    ticks(10);
    chk("R10 no count before start", irq7_o, 0);

    // R2 vector table
    for (int i = 0; i < NVEC; i++) begin
      int p, r;
      logic [15:0] ec;
      p = (V_PER[i] == 16'd0) ? 65536 : int'(V_PER[i]);
      wr(2'd0, V_PER[i]);
      clr_irq();
      ticks(V_TCK[i]);
      r = V_TCK[i] % p;
      ec = (r == 0) ? V_PER[i] : 16'(p - r);
      rd(2'd0, v);
      chk("R2 live count", v, ec);
      chk("R2 irq", irq7_o, (V_TCK[i] >= p) ? 1 : 0);
    end

    // R5 clear alone and same-cycle clear/wrap
    clr_irq();
    chk("R5 clear", irq7_o, 0);
    wr(2'd0, 16'd3);
    ticks(2);
    chk("R5 before wrap", irq7_o, 0);
    @(negedge clk);
    tick_i = 1'b1; irq_clr_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; irq_clr_i = 1'b0;
    chk("R5 wrap wins over clear", irq7_o, 1);
    repeat (3) @(negedge clk);
    chk("R5 stays pending", irq7_o, 1);
    clr_irq();
    chk("R5 cleared later", irq7_o, 0);

    // R4 cannot stop, rewrite restarts
    wr(2'd0, 16'd4);
    clr_irq();
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0000);
    ticks(4);
    chk("R4 runs after wd writes", irq7_o, 1);
    clr_irq();
    wr(2'd0, 16'd4);
    ticks(2);
    wr(2'd0, 16'd6);
    ticks(5);
    chk("R4 reload no irq", irq7_o, 0);
    rd(2'd0, v); chk("R4 reload count", v, 1);
    ticks(1);
    chk("R4 reload irq", irq7_o, 1);

    // R10 / R6 watchdog registers
    wr(2'd1, 16'd10);
    rd(2'd1, v); chk("R10 wdps readback", v, 10);
    wr(2'd2, 16'hFFC0);
    rd(2'd2, v); chk("R6 ctl readback", v, 16'h00C0);
    wr(2'd2, 16'h0040);
    rd(2'd2, v); chk("R6 enable bit", v, 16'h0040);

    // R8 kick
    ticks(6);
    wr(2'd1, 16'd10);
    wr(2'd2, 16'h0040);
    ticks(9);
    chk("R8 no reset after kick", wd_rst_o, 0);
    rd(2'd1, v); chk("R10 wdps not count", v, 10);
    // R7 expiry
    ticks(1);
    chk("R7 reset asserted", wd_rst_o, 1);
    rd(2'd2, v); chk("R7 enable cleared", v, 16'h0000);
    repeat (RST_PULSE - 1) @(negedge clk);
    chk("R7 pulse last cycle", wd_rst_o, 1);
    @(negedge clk);
    chk("R7 pulse ended", wd_rst_o, 0);
    ticks(30);
    chk("R7 disabled after expiry", wd_rst_o, 0);

    // R8 kick in the expiry cycle
    wr(2'd1, 16'd3);
    wr(2'd2, 16'h0040);
    ticks(2);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 2'd2; wr_data_i = 16'h0040;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    chk("R8 kick wins over expiry", wd_rst_o, 0);
    ticks(2);
    chk("R8 restarted count", wd_rst_o, 0);
    ticks(1);
    chk("R8 expiry after full timeout", wd_rst_o, 1);
    repeat (RST_PULSE + 1) @(negedge clk);

    // R9 stop at will
    wr(2'd1, 16'd8);
    wr(2'd2, 16'h0040);
    ticks(5);
    wr(2'd2, 16'h0000);
    ticks(40);
    chk("R9 stopped", wd_rst_o, 0);
    rd(2'd2, v); chk("R9 ctl reads off", v, 0);

    // R3 divide by 65536
    wr(2'd0, 16'd0);
    clr_irq();
    ticks(65535);
    chk("R3 no irq at 65535", irq7_o, 0);
    rd(2'd0, v); chk("R3 count 1", v, 1);
    ticks(1);
    chk("R3 irq at 65536", irq7_o, 1);
    rd(2'd0, v); chk("R3 count wrap", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule